// File: doc/BRIEF.md
# Multiprocessor Address Recognition Filter

This block sits after the receiver of a UART running in a 9-bit multiprocessor mode. Each received frame reaches it as a byte plus a ninth bit, delivered as a one-cycle strobe. A frame whose ninth bit is 1 carries an address. A frame whose ninth bit is 0 carries data. The filter decides whether an address frame selects this node. It then forwards only the frames that the node should see.

Two 8-bit registers set the node's identity: an own-address register and a mask register. They are written through a simple write port. From them the filter forms two patterns and compares every address frame against both of them:
- The unicast pattern compares only the bit positions where the mask is 1.
- The broadcast pattern is the bitwise OR of the own address and the mask. Its 0 bits are don't-care.

A match on either pattern selects the node. Data frames are then forwarded until the next address frame decides again. Several nodes may share one own address and still be told apart by different masks. With common settings the broadcast pattern works out to 0xFF.

When both registers hold zero, every bit of both patterns is don't-care. The filter then passes every frame, so the node behaves as a plain UART. This is also the state after reset.

Top module: `mpf_top`

## Requirements
- R1: After reset both registers are 0x00, `selected_o` is 0, and `out_valid_o` and `addr_hit_o` are 0.
- R2: A write with `cfg_sel_i`=0 loads the own-address register and a write with `cfg_sel_i`=1 loads the mask register. A frame strobed in the same cycle as a write is judged with the old register values; later frames use the new ones. A register not written keeps its value.
- R3: Unicast match: an address frame matches when `rx_data_i` equals the own address at every bit position where the mask bit is 1. Positions where the mask bit is 0 are ignored.
- R4: Broadcast match: with B = own address OR mask, an address frame matches when `rx_data_i` has a 1 at every position where B has a 1. Positions where B is 0 are ignored.
- R5: A matching address frame (`rx_addr_i`=1) produces, in the next cycle, a one-cycle `addr_hit_o` pulse and a forwarded frame with `out_addr_o`=1. From that cycle on, `selected_o` is 1.
- R6: A non-matching address frame produces no pulse and is not forwarded. From the next cycle on, `selected_o` is 0.
- R7: A data frame (`rx_addr_i`=0) is forwarded, with `out_addr_o`=0 and its byte on `out_data_o`, only when `selected_o` is 1 in the cycle the frame is strobed, or when the filter is in its pass-all state (R8). Otherwise it is dropped.
- R8: While both registers are 0x00, every address frame matches and every data frame is forwarded, including data frames that arrive before any address frame.
- R9: Each output frame appears exactly one cycle after its input strobe, with `out_valid_o` high for one cycle. Cycles with no strobe produce no output and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | Register select: 0 = own address, 1 = mask |
| cfg_wdata_i | input | 8 | Register write data |
| rx_valid_i | input | 1 | Received frame strobe, one cycle per frame |
| rx_data_i | input | 8 | Received byte |
| rx_addr_i | input | 1 | Ninth bit: 1 = address frame, 0 = data frame |
| out_valid_o | output | 1 | Forwarded frame strobe |
| out_data_o | output | 8 | Forwarded byte |
| out_addr_o | output | 1 | Forwarded frame was an address frame |
| addr_hit_o | output | 1 | One-cycle pulse on an address match |
| selected_o | output | 1 | Node is selected by the last address frame |

## Verification
The assertions check on every cycle the properties that are local in time:
- a miss clears the selection and produces no output;
- an unselected data frame is dropped unless the filter is in pass-all;
- a pulse always comes with the selected state;
- an idle cycle produces no output;
- both registers at zero force both comparisons to match;
- the registers change only on a write.

Only the bench scenarios can show the arithmetic of the two patterns for chosen values, such as the don't-care bit in the broadcast pattern. The same holds for the one-cycle delay before a register write takes effect, and for selection being kept across a run of data frames. A long stretch of random frames and register writes is compared on every cycle against a behavioural model.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  typedef enum logic {
    CFG_OWN  = 1'b0,
    CFG_MASK = 1'b1
  } cfg_sel_e;

  typedef struct packed {
    logic uni;
    logic bcast;
  } match_t;
endpackage

// File: rtl/mpf_cfg_regs.sv
module mpf_cfg_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] own_o,
  output logic [DATA_W-1:0] mask_o
);
  import mpf_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_o  <= '0;
      mask_o <= '0;
    end else if (we_i) begin
      if (cfg_sel_e'(sel_i) == CFG_OWN) own_o  <= wdata_i;
      else                              mask_o <= wdata_i;
    end
  end

  // R2: registers only move on a write
  a_r2_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(own_o) && $stable(mask_o)));
endmodule

// File: rtl/mpf_addr_cmp.sv
module mpf_addr_cmp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] own_i,
  input  logic [DATA_W-1:0] mask_i,
  output mpf_pkg::match_t   match_o,
  output logic              pass_all_o
);
  logic [DATA_W-1:0] uni_ok;
  logic [DATA_W-1:0] bc_ok;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic bc_bit;
    assign bc_bit    = own_i[i] | mask_i[i];
    // a cared bit must agree; an uncared bit always passes
    assign uni_ok[i] = ~mask_i[i] | ~(data_i[i] ^ own_i[i]);
    assign bc_ok[i]  = ~bc_bit | data_i[i];
  end

  assign match_o.uni   = &uni_ok;
  assign match_o.bcast = &bc_ok;
  assign pass_all_o    = ~|{own_i, mask_i};

  // R8: zero registers make both patterns all don't-care
  always_comb begin
    if (own_i == '0 && mask_i == '0)
      a_r8_zero_all_match: assert (match_o.uni && match_o.bcast);
  end
endmodule

// File: rtl/mpf_frame_gate.sv
module mpf_frame_gate #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              addr_i,
  input  logic              hit_i,
  input  logic              pass_all_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_addr_o,
  output logic              hit_o,
  output logic              sel_o
);
  logic fwd;

  always_comb begin
    if (addr_i) fwd = hit_i;
    else        fwd = sel_o | pass_all_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_addr_o  <= 1'b0;
      hit_o       <= 1'b0;
      sel_o       <= 1'b0;
    end else begin
      out_valid_o <= valid_i & fwd;
      hit_o       <= valid_i & addr_i & hit_i;
      if (valid_i) begin
        out_data_o <= data_i;
        out_addr_o <= addr_i;
        if (addr_i) sel_o <= hit_i;
      end
    end
  end

  a_r6_miss_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_i && !hit_i) |=> (!sel_o && !hit_o && !out_valid_o));

  a_r7_data_needs_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !addr_i && !sel_o && !pass_all_i) |=> !out_valid_o);

  a_r5_hit_selects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (sel_o && out_valid_o && out_addr_o));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!out_valid_o && !hit_o));
endmodule

// File: rtl/mpf_top.sv
module mpf_top #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_addr_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_addr_o,
  output logic              addr_hit_o,
  output logic              selected_o
);
  import mpf_pkg::*;

  logic [DATA_W-1:0] own_q;
  logic [DATA_W-1:0] mask_q;
  match_t            match;
  logic              pass_all;

  mpf_cfg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .sel_i  (cfg_sel_i),
    .wdata_i(cfg_wdata_i),
    .own_o  (own_q),
    .mask_o (mask_q)
  );

  mpf_addr_cmp #(.DATA_W(DATA_W)) u_cmp (
    .data_i    (rx_data_i),
    .own_i     (own_q),
    .mask_i    (mask_q),
    .match_o   (match),
    .pass_all_o(pass_all)
  );

  mpf_frame_gate #(.DATA_W(DATA_W)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (rx_valid_i),
    .data_i     (rx_data_i),
    .addr_i     (rx_addr_i),
    .hit_i      (match.uni | match.bcast),
    .pass_all_i (pass_all),
    .out_valid_o(out_valid_o),
    .out_data_o (out_data_o),
    .out_addr_o (out_addr_o),
    .hit_o      (addr_hit_o),
    .sel_o      (selected_o)
  );

  // R9: every output frame traces back to a strobe one cycle earlier
  a_r9_output_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(rx_valid_i));
endmodule

// File: tb/sim_mpf_top.sv
module sim_mpf_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       rx_valid = 1'b0, rx_addr = 1'b0;
  logic [7:0] rx_data = '0;
  logic       out_valid, out_addr, addr_hit, selected;
  logic [7:0] out_data;

  int total = 0, bad = 0;
  int m_own = 0, m_mask = 0;
  bit m_sel = 0;
  bit e_valid = 0, e_hit = 0, e_addr = 0;
  int e_data = 0;
  string e_tag = "R1";

  always #5 clk = ~clk;

  mpf_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_addr_i(rx_addr),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_addr_o(out_addr),
    .addr_hit_o(addr_hit), .selected_o(selected)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle, update the model, then compare after the edge
  task automatic step(bit we, bit sel, int wd, bit v, int d, bit a9, string tag);
    bit pass_all, uni, bc, hit;
    int bcp;
    pass_all = (m_own == 0) && (m_mask == 0);
    uni = (((d ^ m_own) & m_mask) & 8'hFF) == 0;
    bcp = m_own | m_mask;
    bc  = (d & bcp) == bcp;
    hit = v && a9 && (uni || bc);
    e_hit   = hit;
    e_valid = v && (a9 ? hit : (m_sel || pass_all));
    e_addr  = a9;
    e_data  = d & 8'hFF;
    if (v && a9) m_sel = hit;
    if (we) begin
      if (sel) m_mask = wd & 8'hFF;
      else     m_own  = wd & 8'hFF;
    end
    e_tag = tag;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd[7:0];
    rx_valid = v; rx_data = d[7:0]; rx_addr = a9;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0; rx_valid = 0;
    chk({e_tag, " valid"}, out_valid, e_valid);
    chk({e_tag, " hit"}, addr_hit, e_hit);
    chk({e_tag, " selected"}, selected, m_sel);
    if (e_valid) begin
      chk({e_tag, " data"}, out_data, e_data);
      chk({e_tag, " addr"}, out_addr, e_addr);
    end
  endtask

  task automatic frame(bit a9, int d, string tag);
    step(0, 0, 0, 1, d, a9, tag);
  endtask

  initial begin
    #100000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hang expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 valid", out_valid, 0);
    chk("R1 hit", addr_hit, 0);
    chk("R1 selected", selected, 0);
    step(0, 0, 0, 0, 0, 0, "R9 idle");
    // R8: pass-all, data before any address frame
    frame(0, 8'h3C, "R8 data pass-all");
    frame(1, 8'h12, "R8 addr pass-all");
    // R2: write own address together with a frame, old values used
    step(1, 0, 8'hF1, 1, 8'h00, 1, "R2 same-cycle old regs");
    step(1, 1, 8'hFA, 0, 0, 0, "R2 mask write");
    frame(1, 8'h55, "R6 miss");
    frame(0, 8'hA5, "R7 dropped");
    frame(1, 8'hF1, "R3 exact unicast");
    frame(0, 8'h77, "R7 forwarded");
    frame(0, 8'h78, "R7 forwarded run");
    frame(1, 8'hF3, "R6 miss F3");
    frame(0, 8'h11, "R7 dropped after miss");
    frame(1, 8'hF0, "R3 dont-care bit0");
    frame(1, 8'hFE, "R6 miss FE");
    frame(1, 8'hFF, "R4 broadcast FF");
    frame(1, 8'hFB, "R4 broadcast bit2 dont-care");
    step(0, 0, 0, 0, 0, 0, "R9 idle keeps sel");
    frame(0, 8'h42, "R7 data after bcast");
    // back to pass-all
    step(1, 0, 0, 0, 0, 0, "R2 clear own");
    step(1, 1, 0, 0, 0, 0, "R2 clear mask");
    frame(1, 8'h00, "R8 any addr");
    // random soak
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0)
        step(1, $urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 1),
             $urandom_range(0, 255), $urandom_range(0, 1), "R2 rand write");
      else if (r < 4)
        step(0, 0, 0, 1, ($urandom_range(0, 3) == 0) ? 8'hFF : $urandom_range(0, 255), 1, "R5 rand addr");
      else if (r < 8)
        step(0, 0, 0, 1, $urandom_range(0, 255), 0, "R7 rand data");
      else
        step(0, 0, 0, 0, 0, 0, "R9 rand idle");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule